// File: doc/BRIEF.md
# Interrupt Status Flag Bank with Run-Time Clear Policy

This block holds four interrupt status registers: two alert bytes, a fault status register and a vendor interrupt status register. Single-cycle event pulses from the rest of the chip set individual flag bits. Software reads and writes the bank over a simple register port and enables each flag with its own bit in four enable registers. A single interrupt line is asserted while any enabled flag is set.

Software clears flags in one of two ways, chosen at run time by a policy bit. The policy bit comes from a configuration input and is visible to software as a read-only register. Under the write-one-to-clear policy, writing a 1 to a flag position clears that flag. Under the clear-on-read policy, reading a status register clears every flag the read returned as set. One flag, the receive start-of-packet flag at bit 2 of the first alert register, is exempt from clear-on-read: it is always cleared by writing a 1 to it, whatever the policy.

Top module: `stflag_bank`

## Requirements
- R1: After synchronous reset, all flags, all enables and the policy register are 0, `irq` is 0 and `rd_data` is 0.
- R2: A 1 on bit `8*r+b` of `evt` sets bit b of status register r (address r: 0 alert byte 0, 1 alert byte 1, 2 fault, 3 vendor) at the next clock edge.
- R3: Under the write-one-to-clear policy (policy 0), a write to status address r clears the flags where `wr_data` is 1 and leaves the rest unchanged. Reads clear nothing.
- R4: Under the clear-on-read policy (policy 1), a read of status address r returns the flag values as they were before the read, and only the flags returned as 1 are cleared.
- R5: If a set event and a clear of the same flag occur in the same cycle, whether by write or by read, the flag is 1 afterwards.
- R6: Bit 2 of alert byte 0 (address 0) is never cleared by a read. Under either policy, writing a 1 to it clears it.
- R7: Under the clear-on-read policy, writes to the four status addresses change no flag other than bit 2 of address 0.
- R8: The policy register takes the value of `policy_sel` one clock after it is applied. It reads back at address 8 as bit 0, and writes to address 8 have no effect.
- R9: The enable register for status register r is at address 4+r. It is written with `wr_data` and reads back what was written.
- R10: `irq` is a register equal to the OR over all flags ANDed with their enable bits. It changes one clock after the flag or enable that causes the change.
- R11: `rd_data` is registered. It shows the addressed register one clock after `rd_en`, holds its value while `rd_en` is low, and reads as 0 for unmapped addresses 9 to 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt | input | 32 | Flag set pulses, 8 bits per status register, register 0 in the low byte |
| policy_sel | input | 1 | Clear policy source: 0 write-one-to-clear, 1 clear-on-read |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Register address |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| irq | output | 1 | Combined interrupt, registered |

## Verification
The hardest cases to reach from the ports are those where several things land on one flag in the same cycle: a read under clear-on-read, or a one-write, arriving together with a set pulse on a bit that is already set or about to be set. The same holds for the start-of-packet bit when a read of its register meets a change of policy. Directed sequences line up these collisions on purpose, including reads that repeat immediately after a clear. A long randomized phase then drives dense event pulses together with reads, writes and policy changes, and a behavioural model checks every clock.

// File: rtl/stflag_pkg.sv
`timescale 1ns/1ps
package stflag_pkg;
    localparam int FLAG_W    = 8;
    localparam int NUM_STAT  = 4;
    localparam int ADDR_W    = 4;
    localparam int SOP_BIT   = 2;   // start-of-packet flag inside status register 0
    localparam int SOP_REG   = 0;

    typedef enum logic {
        CLR_W1C     = 1'b0,
        CLR_ON_READ = 1'b1
    } clr_policy_e;

    typedef struct packed {
        logic wr_hit;
        logic rd_hit;
    } reg_access_t;

    function automatic bit holds_sop(input int idx);
        return idx == SOP_REG;
    endfunction
endpackage

// File: rtl/stflag_cell.sv
`timescale 1ns/1ps
module stflag_cell
    import stflag_pkg::*;
#(
    parameter int          W      = FLAG_W,
    parameter logic [W-1:0] EXEMPT = '0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [W-1:0] set_bits,
    input  reg_access_t  acc,
    input  clr_policy_e  policy,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] flags
);
    logic [W-1:0] wr_mask;
    logic [W-1:0] clr_wr;
    logic [W-1:0] clr_rd;
    logic [W-1:0] nxt;

    always_comb begin
        wr_mask = (policy == CLR_ON_READ) ? EXEMPT : '1;
        clr_wr  = acc.wr_hit ? (wr_data & wr_mask) : '0;
        clr_rd  = (acc.rd_hit && policy == CLR_ON_READ) ? (flags & ~EXEMPT) : '0;
        nxt     = (flags & ~(clr_wr | clr_rd)) | set_bits;
    end

    always_ff @(posedge clk) begin
        if (rst) flags <= '0;
        else     flags <= nxt;
    end
endmodule

// File: rtl/stflag_irq.sv
`timescale 1ns/1ps
module stflag_irq #(
    parameter int N = 4,
    parameter int W = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N*W-1:0]  flags,
    input  logic [N*W-1:0]  enables,
    output logic            irq
);
    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= |(flags & enables);
    end
endmodule

// File: rtl/stflag_bank.sv
`timescale 1ns/1ps
module stflag_bank
    import stflag_pkg::*;
#(
    parameter int W   = FLAG_W,
    parameter int N   = NUM_STAT,
    parameter int AW  = ADDR_W,
    parameter int SOP = SOP_BIT
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N*W-1:0] evt,
    input  logic          policy_sel,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wr_data,
    output logic [W-1:0]  rd_data,
    output logic          irq
);
    localparam int EN_BASE   = N;
    localparam int MODE_ADDR = 2 * N;

    clr_policy_e           mode_q;
    logic                  mode_bit;
    logic [N-1:0][W-1:0]   flag_q;
    logic [N-1:0][W-1:0]   en_q;
    logic [N*W-1:0]        flag_flat;
    logic [N*W-1:0]        en_flat;
    logic [W-1:0]          rd_mux;

    always_ff @(posedge clk) begin
        if (rst) mode_q <= CLR_W1C;
        else     mode_q <= clr_policy_e'(policy_sel);
    end
    assign mode_bit = mode_q;

    for (genvar g = 0; g < N; g++) begin : g_stat
        localparam logic [W-1:0] EXM = holds_sop(g) ? (W'(1) << SOP) : '0;
        reg_access_t acc;
        assign acc.wr_hit = wr_en && (addr == AW'(g));
        assign acc.rd_hit = rd_en && (addr == AW'(g));

        stflag_cell #(.W(W), .EXEMPT(EXM)) u_cell (
            .clk     (clk),
            .rst     (rst),
            .set_bits(evt[g*W +: W]),
            .acc     (acc),
            .policy  (mode_q),
            .wr_data (wr_data),
            .flags   (flag_q[g])
        );

        always_ff @(posedge clk) begin
            if (rst)                                       en_q[g] <= '0;
            else if (wr_en && addr == AW'(EN_BASE + g))    en_q[g] <= wr_data;
        end
    end

    assign flag_flat = flag_q;
    assign en_flat   = en_q;

    always_comb begin
        rd_mux = '0;
        for (int i = 0; i < N; i++) begin
            if (addr == AW'(i))           rd_mux = flag_q[i];
            if (addr == AW'(EN_BASE + i)) rd_mux = en_q[i];
        end
        if (addr == AW'(MODE_ADDR)) rd_mux = W'(mode_bit);
    end

    always_ff @(posedge clk) begin
        if (rst)        rd_data <= '0;
        else if (rd_en) rd_data <= rd_mux;
    end

    stflag_irq #(.N(N), .W(W)) u_irq (
        .clk    (clk),
        .rst    (rst),
        .flags  (flag_flat),
        .enables(en_flat),
        .irq    (irq)
    );
endmodule

// File: rtl/stflag_chk.sv
`timescale 1ns/1ps
module stflag_chk #(
    parameter int W   = 8,
    parameter int N   = 4,
    parameter int AW  = 4,
    parameter int SOP = 2
) (
    input logic          clk,
    input logic          rst,
    input logic [N*W-1:0] evt,
    input logic          wr_en,
    input logic          rd_en,
    input logic [AW-1:0] addr,
    input logic          mode,
    input logic [N*W-1:0] flags,
    input logic [N*W-1:0] ens,
    input logic          irq
);
    localparam logic [N*W-1:0] KEEP = ~((N*W)'(1) << SOP);

    // R2
    evt_sets_chk: assert property (@(posedge clk) disable iff (rst)
        (|evt) |=> ((flags & $past(evt)) == $past(evt)));

    // R10
    irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
        (|(flags & ens)) |=> irq);

    // R10
    irq_low_chk: assert property (@(posedge clk) disable iff (rst)
        !(|(flags & ens)) |=> !irq);

    // R3
    w1c_read_keeps_chk: assert property (@(posedge clk) disable iff (rst)
        (!mode && rd_en && !wr_en) |=> ((flags & $past(flags)) == $past(flags)));

    // R6
    sop_read_keeps_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == '0 && !(wr_en && addr == '0) && flags[SOP]) |=> flags[SOP]);

    // R7
    cor_write_keeps_chk: assert property (@(posedge clk) disable iff (rst)
        (mode && wr_en && !rd_en) |=> ((flags & $past(flags) & KEEP) == ($past(flags) & KEEP)));
endmodule

bind stflag_bank stflag_chk #(.W(W), .N(N), .AW(AW), .SOP(SOP)) u_chk (
    .clk  (clk),
    .rst  (rst),
    .evt  (evt),
    .wr_en(wr_en),
    .rd_en(rd_en),
    .addr (addr),
    .mode (mode_bit),
    .flags(flag_flat),
    .ens  (en_flat),
    .irq  (irq)
);

// File: tb/test_stflag_bank.sv
`timescale 1ns/1ps
module test_stflag_bank;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] evt = '0;
    logic        policy_sel = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [3:0]  addr = '0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  rd_data;
    logic        irq;

    int checks = 0;
    int failures = 0;
    string phase = "R1";

    always #10 clk = ~clk;   // 50 MHz

    stflag_bank i_stflag_bank (
        .clk(clk), .rst(rst), .evt(evt), .policy_sel(policy_sel),
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wr_data(wr_data),
        .rd_data(rd_data), .irq(irq)
    );

    // behavioural reference
    int mflag[4];
    int men[4];
    int mmode, mrd, mirq;
    int nrd, nirq, clr;

    function automatic int sop_mask(input int r);
        return (r == 0) ? 4 : 0;
    endfunction

    function automatic int mread(input int a);
        if (a < 4) return mflag[a];
        if (a < 8) return men[a-4];
        if (a == 8) return mmode;
        return 0;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < 4; r++) begin mflag[r] = 0; men[r] = 0; end
            mmode = 0; mrd = 0; mirq = 0;
        end else begin
            nrd = rd_en ? mread(int'(addr)) : mrd;
            nirq = 0;
            for (int r = 0; r < 4; r++) if ((mflag[r] & men[r]) != 0) nirq = 1;
            for (int r = 0; r < 4; r++) begin
                clr = 0;
                if (wr_en && int'(addr) == r) clr = mmode ? (int'(wr_data) & sop_mask(r)) : int'(wr_data);
                if (rd_en && int'(addr) == r && mmode == 1) clr = clr | (mflag[r] & ~sop_mask(r));
                mflag[r] = ((mflag[r] & ~clr) | int'(evt[r*8 +: 8])) & 255;
            end
            if (wr_en && addr >= 4 && addr < 8) men[int'(addr)-4] = int'(wr_data);
            mmode = int'(policy_sel);
            mrd = nrd; mirq = nirq;
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            checks++;
            if (int'(rd_data) != mrd || int'(irq) != mirq) begin
                failures++;
                $display("FAIL %s model: rd_data=%0h irq=%0d expected rd_data=%0h irq=%0d",
                         phase, rd_data, irq, mrd, mirq);
            end
        end
    end

    task automatic cyc(input logic [31:0] e, input logic we, input logic re,
                       input int a, input int d);
        @(posedge clk); #5;
        evt = e; wr_en = we; rd_en = re; addr = 4'(a); wr_data = 8'(d);
    endtask

    task automatic idle(); cyc(0, 0, 0, 0, 0); endtask

    task automatic expect_rd(input int a, input int exp, input string tag);
        cyc(0, 0, 1, a, 0);
        idle();
        @(negedge clk);
        checks++;
        if (int'(rd_data) != exp) begin
            failures++;
            $display("FAIL %s read addr %0d: actual %0h expected %0h", tag, a, rd_data, exp);
        end
    endtask

    task automatic expect_irq(input int exp, input string tag);
        idle(); idle();
        @(negedge clk);
        checks++;
        if (int'(irq) != exp) begin
            failures++;
            $display("FAIL %s irq: actual %0d expected %0d", tag, irq, exp);
        end
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        repeat (3) @(posedge clk);
        #5 rst = 1'b0;
        // R1 reset state
        phase = "R1";
        @(negedge clk);
        checks++;
        if (irq !== 1'b0 || rd_data !== 8'h00) begin
            failures++;
            $display("FAIL R1 outputs: actual irq=%0d rd=%0h expected 0 0", irq, rd_data);
        end
        for (int a = 0; a < 9; a++) expect_rd(a, 0, "R1");

        // R2 / R3 write-one-to-clear policy
        phase = "R3";
        cyc(32'h0081_000F, 0, 0, 0, 0);
        expect_rd(0, 8'h0F, "R2");
        expect_rd(2, 8'h81, "R2");
        expect_rd(0, 8'h0F, "R3");
        cyc(0, 1, 0, 0, 8'h05);
        expect_rd(0, 8'h0A, "R3");
        expect_rd(12, 0, "R11");

        // R9 / R10 enables and interrupt
        phase = "R10";
        expect_irq(0, "R10");
        cyc(0, 1, 0, 4, 8'h08);
        expect_irq(1, "R10");
        expect_rd(4, 8'h08, "R9");
        cyc(0, 1, 0, 0, 8'h08);
        expect_irq(0, "R10");

        // R5 set wins against a write clear
        phase = "R5";
        cyc(32'h0000_0008, 1, 0, 0, 8'h08);
        expect_rd(0, 8'h0A, "R5");

        // R8 policy register
        phase = "R8";
        policy_sel = 1'b1;
        idle();
        expect_rd(8, 1, "R8");
        cyc(0, 1, 0, 8, 0);
        expect_rd(8, 1, "R8");

        // R4 / R6 clear-on-read
        phase = "R4";
        cyc(32'h0000_0004, 0, 0, 0, 0);
        expect_rd(0, 8'h0E, "R4");
        expect_rd(0, 8'h04, "R6");
        cyc(32'h0000_3000, 0, 0, 0, 0);
        cyc(0, 1, 0, 1, 8'hFF);
        expect_rd(1, 8'h30, "R7");
        expect_rd(1, 8'h00, "R4");
        cyc(0, 1, 0, 0, 8'hFF);
        expect_rd(0, 8'h00, "R6");

        // R5 set wins against a read clear
        phase = "R5";
        cyc(32'h0100_0000, 0, 0, 0, 0);
        cyc(32'h0100_0000, 0, 1, 3, 0);
        idle();
        @(negedge clk);
        checks++;
        if (rd_data !== 8'h01) begin
            failures++;
            $display("FAIL R5 read during set: actual %0h expected 01", rd_data);
        end
        expect_rd(3, 8'h01, "R5");

        // back to write-one-to-clear: sop bit survives reads
        phase = "R6";
        policy_sel = 1'b0;
        cyc(32'h0000_0004, 0, 0, 0, 0);
        expect_rd(0, 8'h04, "R6");
        expect_rd(0, 8'h04, "R3");

        // randomized phase, reference compared every clock (R2..R11)
        phase = "R11";
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] e;
            e = (($urandom % 3) == 0) ? ($urandom & $urandom) : 32'h0;
            if (($urandom % 64) == 0) policy_sel = ~policy_sel;
            cyc(e, ($urandom % 4) == 0, ($urandom % 3) == 0, $urandom % 16, $urandom);
        end
        idle(); idle();
        @(negedge clk);
        report();
    end
endmodule